// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers a set of event sources into two status registers, filters them through two mask registers, and drives a single active-low interrupt request line toward a host. The host reaches the block over a small register bus: an 8-bit address, 8-bit write data with a write strobe, and a read strobe. Read data is combinational on the address.

The sources behave in different ways. A microphone short sense input is synchronised and then debounced over a long interval in both directions. Its status bit follows the filtered level and is not sticky, and it raises an event on both edges. That input only counts while the microphone bias is powered. A thermal overload flag, gated by a thermal-sensing enable, and three overflow flags are sticky and raise an event only on a rising edge. Six converter lock flags are shown live in a second status register and raise an event on a rising edge. Reading a status register clears its latched events and any sticky bits in it.

Top module: `irq_stat_ctrl`

## Requirements
- R1: After reset both mask registers read 0x00 and `irq_n` is 1. A write to 0x5E sets the first mask and a write to 0x5F sets the second. Only implemented bits are kept: 0x5B in the first mask and 0x3F in the second. Unimplemented bits read 0.
- R2: The first status register at 0x60 has this layout: bit 6 microphone short, bit 4 thermal overload, bit 3 mixer overflow, bit 1 path-B overflow, bit 0 path-A overflow. Bits 7, 5 and 2 always read 0. Writes to 0x60 have no effect.
- R3: Bit 6 of 0x60 shows the debounced microphone short level (1 = short) and is not sticky. A new level on `mic_short_raw` is accepted only after it has been held for DB_MS milliseconds of CLK_KHZ clock, with two synchroniser stages added before that. A pulse shorter than the interval is ignored.
- R4: Both the rising and the falling debounced edge of the microphone short raise an event.
- R5: While `bias_pdn` or `global_pdn` is 1, bit 6 reads 0. A debounced change that completes during that time raises no event.
- R6: Thermal overload is recorded only while `therm_sense_en` is 1. Bit 4 is sticky until it is read, and only the rising edge of the flag raises an event.
- R7: The three overflow inputs each set their sticky bit (3, 1, 0). The rising edge of each raises an event.
- R8: The second status register at 0x61 shows `lock_flags` live in bits 5..0, and bits 7..6 read 0. A rising edge of any lock flag raises an event. Reading 0x61 clears those events.
- R9: `irq_n` is 0 exactly when a latched event has its mask bit at 1. A mask bit of 0 blocks its event from the output, but the status bit still shows the source.
- R10: A read strobe on 0x60 clears the sticky bits and latched events of the first register. An event or sticky set that arrives in the same cycle as the clearing read is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe; clears on status reads |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| mic_short_raw | input | 1 | Asynchronous microphone short sense |
| bias_pdn | input | 1 | Microphone bias power-down |
| global_pdn | input | 1 | Global power-down |
| therm_sense_en | input | 1 | Thermal sensing enable |
| therm_over | input | 1 | Thermal overload flag |
| mix_ovf | input | 1 | Digital mixer overflow flag |
| pathb_ovf | input | 1 | Input path B overflow flag |
| patha_ovf | input | 1 | Input path A overflow flag |
| lock_flags | input | 6 | Converter lock flags |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The embedded properties check the following on every cycle:
- Sticky bits and latched events never drop unless a clearing read is present.
- A mask write stores only the implemented bits.
- The debounced level changes only after a full run of disagreeing samples.
- Reserved status bits read zero.

Other behaviour needs the directed scenarios to show it:
- Rejection of a short glitch.
- The event on the falling microphone edge.
- Loss of events while the bias or thermal sensing is off.
- An event kept when it lands in the cycle of its clearing read.
- An interrupt that appears once its mask is opened.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam logic [7:0] ADDR_MASK1 = 8'h5E;
    localparam logic [7:0] ADDR_MASK2 = 8'h5F;
    localparam logic [7:0] ADDR_STAT1 = 8'h60;
    localparam logic [7:0] ADDR_STAT2 = 8'h61;

    localparam int BIT_MIC   = 6;
    localparam int BIT_THERM = 4;
    localparam int BIT_MIX   = 3;
    localparam int BIT_PATHB = 1;
    localparam int BIT_PATHA = 0;

    localparam logic [7:0] IMPL1   = 8'h5B;
    localparam logic [7:0] STICKY1 = 8'h1B;
    localparam logic [7:0] BOTH1   = 8'h40;
    localparam logic [7:0] IMPL2   = 8'h3F;
    localparam logic [7:0] STICKY2 = 8'h00;
    localparam logic [7:0] BOTH2   = 8'h00;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MASK1,
        SEL_MASK2,
        SEL_STAT1,
        SEL_STAT2
    } reg_sel_e;

    typedef struct packed {
        logic [7:0] lvl;
        logic [7:0] en;
    } src_vec_t;

    function automatic reg_sel_e decode_addr(input logic [7:0] a);
        case (a)
            ADDR_MASK1: return SEL_MASK1;
            ADDR_MASK2: return SEL_MASK2;
            ADDR_STAT1: return SEL_STAT1;
            ADDR_STAT2: return SEL_STAT2;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irq_debounce.sv
module irq_debounce #(
    parameter int DB_CYCLES = 2000000
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic level_out
);
    localparam int CNT_W = (DB_CYCLES > 2) ? $clog2(DB_CYCLES) : 1;
    localparam logic [CNT_W-1:0] TERM = CNT_W'(DB_CYCLES - 1);

    logic [1:0]       sync_q;
    logic             stable_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '0;
            stable_q <= 1'b0;
            cnt_q    <= '0;
        end else begin
            sync_q <= {sync_q[0], raw_in};
            if (sync_q[1] == stable_q) begin
                cnt_q <= '0;
            end else if (cnt_q == TERM) begin
                stable_q <= sync_q[1];
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign level_out = stable_q;

    // R3
    db_full_run_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(stable_q) |-> ($past(cnt_q) == TERM && $past(sync_q[1]) != $past(stable_q)));

endmodule

// File: rtl/irq_evt_bank.sv
module irq_evt_bank #(
    parameter logic [7:0] IMPL   = 8'hFF,
    parameter logic [7:0] STICKY = 8'h00,
    parameter logic [7:0] BOTH   = 8'h00
) (
    input  logic                clk,
    input  logic                rst,
    input  irq_pkg::src_vec_t   src,
    input  logic                clr,
    output logic [7:0]          status,
    output logic [7:0]          evt
);
    for (genvar i = 0; i < 8; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            logic prev_q;
            logic ev_q;
            logic rise;
            logic fall;
            logic hit;

            assign rise = src.lvl[i] & ~prev_q;
            assign fall = ~src.lvl[i] & prev_q;
            assign hit  = src.en[i] & (rise | (BOTH[i] & fall));

            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q <= 1'b0;
                    ev_q   <= 1'b0;
                end else begin
                    prev_q <= src.lvl[i];
                    ev_q   <= (ev_q & ~clr) | hit;
                end
            end
            assign evt[i] = ev_q;

            if (STICKY[i]) begin : g_sticky
                logic stk_q;
                always_ff @(posedge clk) begin
                    if (rst) stk_q <= 1'b0;
                    else     stk_q <= (stk_q & ~clr) | (src.lvl[i] & src.en[i]);
                end
                assign status[i] = stk_q;
            end else begin : g_live
                assign status[i] = src.lvl[i] & src.en[i];
            end
        end else begin : g_rsvd
            assign status[i] = 1'b0;
            assign evt[i]    = 1'b0;
        end
    end

    // R10
    evt_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((evt & $past(evt)) == $past(evt)));

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((status & STICKY & $past(status & STICKY)) == $past(status & STICKY)));

endmodule

// File: rtl/irq_stat_ctrl.sv
module irq_stat_ctrl #(
    parameter int CLK_KHZ = 100000,
    parameter int DB_MS   = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic       reg_we,
    input  logic       reg_re,
    output logic [7:0] reg_rdata,
    input  logic       mic_short_raw,
    input  logic       bias_pdn,
    input  logic       global_pdn,
    input  logic       therm_sense_en,
    input  logic       therm_over,
    input  logic       mix_ovf,
    input  logic       pathb_ovf,
    input  logic       patha_ovf,
    input  logic [5:0] lock_flags,
    output logic       irq_n
);
    import irq_pkg::*;

    localparam int DB_CYCLES = CLK_KHZ * DB_MS;

    reg_sel_e   sel;
    logic [7:0] mask1_q, mask2_q;
    logic [7:0] stat1, stat2, evt1, evt2;
    logic       mic_lvl, bias_on;
    logic       clr1, clr2;
    src_vec_t   src1, src2;

    assign sel     = decode_addr(reg_addr);
    assign bias_on = ~bias_pdn & ~global_pdn;
    assign clr1    = reg_re && (sel == SEL_STAT1);
    assign clr2    = reg_re && (sel == SEL_STAT2);

    irq_debounce #(.DB_CYCLES(DB_CYCLES)) mic_db_i (
        .clk      (clk),
        .rst      (rst),
        .raw_in   (mic_short_raw),
        .level_out(mic_lvl)
    );

    always_comb begin
        src1 = '0;
        src1.lvl[BIT_MIC]   = mic_lvl;
        src1.en[BIT_MIC]    = bias_on;
        src1.lvl[BIT_THERM] = therm_over;
        src1.en[BIT_THERM]  = therm_sense_en;
        src1.lvl[BIT_MIX]   = mix_ovf;
        src1.en[BIT_MIX]    = 1'b1;
        src1.lvl[BIT_PATHB] = pathb_ovf;
        src1.en[BIT_PATHB]  = 1'b1;
        src1.lvl[BIT_PATHA] = patha_ovf;
        src1.en[BIT_PATHA]  = 1'b1;
        src2.lvl = {2'b00, lock_flags};
        src2.en  = IMPL2;
    end

    irq_evt_bank #(.IMPL(IMPL1), .STICKY(STICKY1), .BOTH(BOTH1)) bank1_i (
        .clk(clk), .rst(rst), .src(src1), .clr(clr1), .status(stat1), .evt(evt1)
    );

    irq_evt_bank #(.IMPL(IMPL2), .STICKY(STICKY2), .BOTH(BOTH2)) bank2_i (
        .clk(clk), .rst(rst), .src(src2), .clr(clr2), .status(stat2), .evt(evt2)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask1_q <= '0;
            mask2_q <= '0;
        end else if (reg_we) begin
            if (sel == SEL_MASK1) mask1_q <= reg_wdata & IMPL1;
            if (sel == SEL_MASK2) mask2_q <= reg_wdata & IMPL2;
        end
    end

    always_comb begin
        case (sel)
            SEL_MASK1: reg_rdata = mask1_q;
            SEL_MASK2: reg_rdata = mask2_q;
            SEL_STAT1: reg_rdata = stat1;
            SEL_STAT2: reg_rdata = stat2;
            default:   reg_rdata = 8'h00;
        endcase
    end

    assign irq_n = ~|((evt1 & mask1_q) | (evt2 & mask2_q));

    // R1
    mask_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == ADDR_MASK1) |=> (mask1_q == ($past(reg_wdata) & IMPL1)));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_STAT1) |-> ((reg_rdata & ~IMPL1) == 8'h00));

    // R5
    bias_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!bias_on && !clr1 && !$past(evt1[BIT_MIC])) |=> !evt1[BIT_MIC]);

endmodule

// File: tb/irq_stat_ctrl_tb_top.sv
module irq_stat_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
    logic       reg_we = 1'b0, reg_re = 1'b0;
    logic [7:0] reg_rdata;
    logic       mic_short_raw = 1'b0, bias_pdn = 1'b0, global_pdn = 1'b0;
    logic       therm_sense_en = 1'b0, therm_over = 1'b0;
    logic       mix_ovf = 1'b0, pathb_ovf = 1'b0, patha_ovf = 1'b0;
    logic [5:0] lock_flags = 6'd0;
    logic       irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_stat_ctrl #(.CLK_KHZ(1), .DB_MS(20)) dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
        .mic_short_raw(mic_short_raw), .bias_pdn(bias_pdn), .global_pdn(global_pdn),
        .therm_sense_en(therm_sense_en), .therm_over(therm_over),
        .mix_ovf(mix_ovf), .pathb_ovf(pathb_ovf), .patha_ovf(patha_ovf),
        .lock_flags(lock_flags), .irq_n(irq_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b0;
        #1 v = reg_rdata;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic expect_reg(input logic [7:0] a, input logic [7:0] exp, input string req);
        logic [7:0] v;
        peek(a, v);
        check(v == exp, req, v, exp);
    endtask

    task automatic expect_irq(input logic exp, input string req);
        #1 check(irq_n == exp, req, irq_n, exp);
    endtask

    task automatic t_reset;
        expect_irq(1'b1, "R1 irq idle");
        expect_reg(8'h5E, 8'h00, "R1 mask1 reset");
        expect_reg(8'h5F, 8'h00, "R1 mask2 reset");
        expect_reg(8'h60, 8'h00, "R2 stat1 reset");
    endtask

    task automatic t_masks;
        wr(8'h5E, 8'hFF);
        expect_reg(8'h5E, 8'h5B, "R1 mask1 implemented bits");
        wr(8'h5F, 8'hFF);
        expect_reg(8'h5F, 8'h3F, "R1 mask2 implemented bits");
        wr(8'h60, 8'hFF);
        expect_reg(8'h60, 8'h00, "R2 status write ignored");
        expect_irq(1'b1, "R2 status write raises nothing");
    endtask

    task automatic t_overflow;
        logic [7:0] v;
        @(negedge clk); patha_ovf = 1'b1;
        @(negedge clk); patha_ovf = 1'b0;
        expect_reg(8'h60, 8'h01, "R7 path A sticky");
        expect_irq(1'b0, "R7 path A event");
        rd(8'h60, v);
        check(v == 8'h01, "R10 read returns value", v, 8'h01);
        expect_reg(8'h60, 8'h00, "R10 read clears sticky");
        expect_irq(1'b1, "R10 read clears event");
        wr(8'h5E, 8'h00);
        @(negedge clk); pathb_ovf = 1'b1;
        @(negedge clk); pathb_ovf = 1'b0;
        expect_reg(8'h60, 8'h02, "R9 masked status visible");
        expect_irq(1'b1, "R9 masked event blocked");
        wr(8'h5E, 8'h02);
        expect_irq(1'b0, "R9 unmask shows latched event");
        rd(8'h60, v);
        expect_irq(1'b1, "R10 clear path B");
        wr(8'h5E, 8'h5B);
        @(negedge clk);
        reg_addr = 8'h60; reg_re = 1'b1; mix_ovf = 1'b1;
        @(negedge clk);
        reg_re = 1'b0; mix_ovf = 1'b0;
        expect_reg(8'h60, 8'h08, "R10 same-cycle sticky kept");
        expect_irq(1'b0, "R10 same-cycle event kept");
        rd(8'h60, v);
        expect_irq(1'b1, "R7 mixer cleared");
    endtask

    task automatic t_thermal;
        logic [7:0] v;
        @(negedge clk); therm_sense_en = 1'b0; therm_over = 1'b1;
        wait_cyc(3);
        expect_reg(8'h60, 8'h00, "R6 sensing off no status");
        expect_irq(1'b1, "R6 sensing off no event");
        therm_over = 1'b0; therm_sense_en = 1'b1;
        wait_cyc(1);
        therm_over = 1'b1;
        wait_cyc(2);
        expect_reg(8'h60, 8'h10, "R6 overload status");
        expect_irq(1'b0, "R6 rising event");
        therm_over = 1'b0;
        wait_cyc(2);
        expect_reg(8'h60, 8'h10, "R6 sticky after flag drops");
        rd(8'h60, v);
        expect_reg(8'h60, 8'h00, "R6 cleared by read");
        expect_irq(1'b1, "R6 falling edge no event");
    endtask

    task automatic t_mic;
        logic [7:0] v;
        @(negedge clk); mic_short_raw = 1'b1;
        wait_cyc(10);
        mic_short_raw = 1'b0;
        wait_cyc(40);
        expect_reg(8'h60, 8'h00, "R3 glitch ignored");
        expect_irq(1'b1, "R3 glitch no event");
        mic_short_raw = 1'b1;
        wait_cyc(15);
        expect_reg(8'h60, 8'h00, "R3 not accepted early");
        wait_cyc(15);
        expect_reg(8'h60, 8'h40, "R3 short accepted");
        expect_irq(1'b0, "R4 rising event");
        rd(8'h60, v);
        expect_irq(1'b1, "R10 mic event cleared");
        expect_reg(8'h60, 8'h40, "R3 live bit not cleared");
        mic_short_raw = 1'b0;
        wait_cyc(30);
        expect_reg(8'h60, 8'h00, "R3 short released");
        expect_irq(1'b0, "R4 falling event");
        rd(8'h60, v);
        @(negedge clk); global_pdn = 1'b1; mic_short_raw = 1'b1;
        wait_cyc(30);
        expect_reg(8'h60, 8'h00, "R5 bias off reads 0");
        expect_irq(1'b1, "R5 bias off no event");
        global_pdn = 1'b0;
        expect_reg(8'h60, 8'h40, "R5 bias on shows level");
        expect_irq(1'b1, "R5 change during bias off stays silent");
        mic_short_raw = 1'b0;
        wait_cyc(30);
        rd(8'h60, v);
    endtask

    task automatic t_lock;
        logic [7:0] v;
        @(negedge clk); lock_flags = 6'b000100;
        wait_cyc(1);
        expect_reg(8'h61, 8'h04, "R8 lock live");
        expect_irq(1'b0, "R8 lock rising event");
        rd(8'h61, v);
        expect_irq(1'b1, "R8 read clears lock event");
        expect_reg(8'h61, 8'h04, "R8 lock still live");
        lock_flags = 6'b000000;
        wait_cyc(1);
        expect_reg(8'h61, 8'h00, "R8 lock dropped");
        expect_irq(1'b1, "R8 falling no event");
    endtask

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        t_reset();
        t_masks();
        t_overflow();
        t_thermal();
        t_mic();
        t_lock();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule